// File: doc/BRIEF.md
# Edge-Triggered Parallel Input Port with Interrupt

This block is a small bus peripheral. It offers one 8-bit input port, one edge-sensitive strobe input and one software-driven handshake output. It also drives an active-low interrupt request. A host reaches four registers through a chip select, a read/write line, a 4-bit register address and 8-bit write and read buses. All of these are sampled on the system clock.

The strobe input passes through a synchronizer. An edge of the programmed polarity on it sets an interrupt flag, and the interrupt line goes low while that flag and its enable are both set. Any read or write of the port data register clears the flag. A second strobe edge that arrives while the flag is still set is absorbed, not counted. If software services the interrupt by first touching the port, then the port access clears the flag, and the later strobe that the flag absorbed raises no interrupt. The handshake output is held low or high by software, and each change takes effect in the same clock as the control write.

Register addresses are: port data = 1, control = 12, flag = 13, enable = 14. The port data register has no storage.

Top module: `pio_edge_irq`

## Requirements
- R1: After reset all flags, enables and the control register are zero, the handshake output `hs_out` is 1 and `irq_n` is 1.
- R2: With control bit 0 = 0, a falling edge on `strobe` sets flag bit 1. With control bit 0 = 1, a rising edge sets it. An edge of the other direction leaves the flag unchanged.
- R3: A read or a write at address 1 (port data) clears flag bit 1.
- R4: A strobe edge while flag bit 1 is already set has no effect. A later port access clears the flag, and `irq_n` then stays high.
- R5: `irq_n` is low, one clock after the fact, exactly when some flag bit and its enable bit are both set.
- R6: A write to address 14 with bit 7 = 1 sets the enable bits given by ones in bits 6:0. With bit 7 = 0 it clears them. A read returns bit 7 as 1 and the enables in bits 6:0.
- R7: A read of address 13 returns the flags in bits 6:0, and in bit 7 the OR of the flags that are both set and enabled. Writing a 1 to a flag bit clears that flag.
- R8: Control bits 3:1 set the handshake mode. Mode 110 drives `hs_out` low and every other mode drives it high. The new level appears in the same clock edge that stores the control write.
- R9: If an active strobe edge and a port access fall in the same clock, the flag ends set.
- R10: A strobe level held for two clocks or more gives exactly one edge event. A new active edge after such a pulse is detected.
- R11: A read of address 1 returns the live `port_in` pins. A read of an unmapped address returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | system clock |
| rst | input | 1 | synchronous active-high reset |
| cs | input | 1 | register access strobe |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 4 | register address |
| wdata | input | 8 | write data |
| rdata | output | 8 | read data, registered, valid the clock after the read |
| port_in | input | 8 | parallel input pins |
| strobe | input | 1 | asynchronous edge-sensitive data-ready input |
| hs_out | output | 1 | software-driven handshake output |
| irq_n | output | 1 | active-low interrupt request |

## Verification
The two functions that can fall in the same cycle are a synchronized strobe edge setting the flag and a port access clearing it. The bench lowers the strobe half a clock after an edge. It then waits the two synchronizer edges and places a port read so that the read is sampled at the edge where the flag would be set. The bench judges the outcome through the flag register and `irq_n`: the flag must stay set and the interrupt must assert. A separate run services the flag late, after an absorbed second edge, and checks that this second edge is lost.

// File: rtl/pio_pkg.sv
package pio_pkg;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_PORT = 4'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 4'd12;
  localparam logic [ADDR_W-1:0] A_FLAG = 4'd13;
  localparam logic [ADDR_W-1:0] A_ENAB = 4'd14;
  localparam int STROBE_FLAG = 1;
  localparam logic [2:0] HS_DRIVE_LOW = 3'b110;

  typedef struct packed {
    logic [DATA_W-5:0] spare;
    logic [2:0]        hs_mode;
    logic              rise_sel;
  } ctrl_t;
endpackage

// File: rtl/pio_edge_sync.sv
module pio_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin,
  input  logic rise_sel,
  output logic edge_evt
);
  logic [STAGES-1:0] chain;
  logic              prev;
  logic              cur;

  assign cur = chain[STAGES-1];

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], pin};
      prev  <= cur;
    end
  end

  always_comb begin
    if (rise_sel) edge_evt = cur & ~prev;
    else          edge_evt = ~cur & prev;
  end
endmodule

// File: rtl/pio_irq_ctrl.sv
module pio_irq_ctrl #(
  parameter int DATA_W   = 8,
  parameter int EDGE_BIT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              edge_evt,
  input  logic              port_hit,
  input  logic              flag_wr,
  input  logic              enab_wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-2:0] ifr,
  output logic [DATA_W-2:0] ier,
  output logic              irq_n
);
  localparam int NF = DATA_W - 1;

  logic [NF-1:0] set_vec;
  logic [NF-1:0] clr_vec;

  always_comb begin
    set_vec = '0;
    set_vec[EDGE_BIT] = edge_evt;
    clr_vec = flag_wr ? wdata[NF-1:0] : '0;
    if (port_hit) clr_vec[EDGE_BIT] = 1'b1;
  end

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_ff @(posedge clk) begin
      if (rst) ifr[i] <= 1'b0;
      else     ifr[i] <= set_vec[i] | (ifr[i] & ~clr_vec[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier <= '0;
    end else if (enab_wr) begin
      if (wdata[NF]) ier <= ier | wdata[NF-1:0];
      else           ier <= ier & ~wdata[NF-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n <= 1'b1;
    else     irq_n <= ~|(ifr & ier);
  end
endmodule

// File: rtl/pio_edge_irq.sv
module pio_edge_irq
  import pio_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic [DATA_W-1:0] port_in,
  input  logic              strobe,
  output logic              hs_out,
  output logic              irq_n
);
  ctrl_t             ctrl_q;
  logic              edge_evt;
  logic [DATA_W-2:0] ifr_q;
  logic [DATA_W-2:0] ier_q;
  logic              wr_en;
  logic              port_hit;

  assign wr_en    = cs & ~rw;
  assign port_hit = cs & (addr == A_PORT);

  pio_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .pin(strobe),
    .rise_sel(ctrl_q.rise_sel), .edge_evt(edge_evt)
  );

  pio_irq_ctrl #(.DATA_W(DATA_W), .EDGE_BIT(STROBE_FLAG)) u_irq (
    .clk(clk), .rst(rst), .edge_evt(edge_evt), .port_hit(port_hit),
    .flag_wr(wr_en & (addr == A_FLAG)),
    .enab_wr(wr_en & (addr == A_ENAB)),
    .wdata(wdata), .ifr(ifr_q), .ier(ier_q), .irq_n(irq_n)
  );

  // control register and handshake output share one write edge
  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      hs_out <= 1'b1;
    end else if (wr_en && addr == A_CTRL) begin
      ctrl_q <= ctrl_t'(wdata);
      hs_out <= (wdata[3:1] != HS_DRIVE_LOW);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (cs && rw) begin
      case (addr)
        A_PORT:  rdata <= port_in;
        A_CTRL:  rdata <= ctrl_q;
        A_FLAG:  rdata <= {|(ifr_q & ier_q), ifr_q};
        A_ENAB:  rdata <= {1'b1, ier_q};
        default: rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pio_edge_irq_chk.sv
module pio_edge_irq_chk
  import pio_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic [DATA_W-1:0] wdata,
  input logic              hs_out,
  input logic              irq_n,
  input logic              edge_evt,
  input logic [DATA_W-2:0] ifr,
  input logic [DATA_W-2:0] ier
);
  logic past_ok;
  always_ff @(posedge clk) past_ok <= ~rst;

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (irq_n && hs_out && ifr == '0 && ier == '0));

  a_r2_edge_sets_flag: assert property (@(posedge clk) disable iff (rst)
    edge_evt |=> ifr[STROBE_FLAG]);

  a_r3_port_clears: assert property (@(posedge clk) disable iff (rst)
    (cs && addr == A_PORT && !edge_evt) |=> !ifr[STROBE_FLAG]);

  // R4: a set flag is only left by a port access or a flag write
  a_r4_flag_holds: assert property (@(posedge clk) disable iff (rst)
    (ifr[STROBE_FLAG] && !cs) |=> ifr[STROBE_FLAG]);

  a_r5_irq_follows: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (irq_n == !$past(|(ifr & ier))));

  a_r8_hs_low: assert property (@(posedge clk) disable iff (rst)
    (cs && !rw && addr == A_CTRL && wdata[3:1] == HS_DRIVE_LOW) |=> !hs_out);
endmodule

bind pio_edge_irq pio_edge_irq_chk u_chk (
  .clk(clk), .rst(rst), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
  .hs_out(hs_out), .irq_n(irq_n), .edge_evt(edge_evt),
  .ifr(ifr_q), .ier(ier_q)
);

// File: tb/test_pio_edge_irq.sv
module test_pio_edge_irq;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs = 1'b0;
  logic       rw = 1'b1;
  logic [3:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic [7:0] port_in = 8'h00;
  logic       strobe = 1'b1;
  logic       hs_out;
  logic       irq_n;

  int errors = 0;
  int checks = 0;

  always #5 clk = ~clk;

  pio_edge_irq i_pio_edge_irq (
    .clk(clk), .rst(rst), .cs(cs), .rw(rw), .addr(addr), .wdata(wdata),
    .rdata(rdata), .port_in(port_in), .strobe(strobe),
    .hs_out(hs_out), .irq_n(irq_n)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] a, output logic [7:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b1; addr = a;
    @(negedge clk); cs = 1'b0; d = rdata;
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs = 1'b1; rw = 1'b0; addr = a; wdata = d;
    @(negedge clk); cs = 1'b0; rw = 1'b1;
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_strobe(input logic v);
    @(negedge clk); strobe = v; settle(5);
  endtask

  task automatic t_reset;
    logic [7:0] d;
    check("R1 irq_n", {7'd0, irq_n}, 8'h01);
    check("R1 hs_out", {7'd0, hs_out}, 8'h01);
    rd(4'd13, d); check("R1 flags", d, 8'h00);
    rd(4'd14, d); check("R1 enables / R6 bit7", d, 8'h80);
    rd(4'd12, d); check("R1 control", d, 8'h00);
  endtask

  task automatic t_port_read;
    logic [7:0] d;
    port_in = 8'hA5; rd(4'd1, d); check("R11 port pins", d, 8'hA5);
    port_in = 8'h3C; rd(4'd1, d); check("R11 port pins live", d, 8'h3C);
    rd(4'd3, d); check("R11 unmapped", d, 8'h00);
  endtask

  task automatic t_fall_edge;
    logic [7:0] d;
    wr(4'd14, 8'h82);
    rd(4'd14, d); check("R6 enable set", d, 8'h82);
    set_strobe(1'b0);
    check("R2/R5 irq on falling", {7'd0, irq_n}, 8'h00);
    rd(4'd13, d); check("R7 flag read", d, 8'h82);
    rd(4'd1, d); settle(2);
    check("R3 irq released after port read", {7'd0, irq_n}, 8'h01);
    rd(4'd13, d); check("R3 flag cleared by read", d, 8'h00);
    set_strobe(1'b1);
    rd(4'd13, d); check("R2 rising ignored in falling mode", d, 8'h00);
  endtask

  task automatic t_write_clears;
    logic [7:0] d;
    set_strobe(1'b0);
    wr(4'd1, 8'hFF); settle(2);
    rd(4'd13, d); check("R3 flag cleared by write", d, 8'h00);
    set_strobe(1'b1);
    set_strobe(1'b0);
    wr(4'd13, 8'h02); settle(2);
    rd(4'd13, d); check("R7 write-one clears", d, 8'h00);
    check("R5 irq released", {7'd0, irq_n}, 8'h01);
    set_strobe(1'b1);
  endtask

  task automatic t_enable_gate;
    logic [7:0] d;
    set_strobe(1'b0);
    check("R5 irq low with enable", {7'd0, irq_n}, 8'h00);
    wr(4'd14, 8'h02); settle(1);
    check("R5 irq high when disabled", {7'd0, irq_n}, 8'h01);
    rd(4'd14, d); check("R6 enable cleared", d, 8'h80);
    rd(4'd13, d); check("R7 bit7 needs enable", d, 8'h02);
    wr(4'd14, 8'h82); settle(1);
    check("R5 irq back on enable", {7'd0, irq_n}, 8'h00);
    rd(4'd1, d); set_strobe(1'b1);
  endtask

  task automatic t_lost_edge;
    logic [7:0] d;
    set_strobe(1'b0);
    check("R4 first edge irq", {7'd0, irq_n}, 8'h00);
    set_strobe(1'b1);
    set_strobe(1'b0);
    rd(4'd1, d); settle(3);
    check("R4 absorbed edge gives no irq", {7'd0, irq_n}, 8'h01);
    rd(4'd13, d); check("R4 flag clear after late access", d, 8'h00);
    set_strobe(1'b1);
  endtask

  task automatic t_short_pulse;
    logic [7:0] d;
    @(negedge clk); strobe = 1'b0; settle(2);
    @(negedge clk); strobe = 1'b1; settle(1);
    @(negedge clk); strobe = 1'b0; settle(4);
    rd(4'd13, d); check("R10 two-clock pulse seen", d, 8'h82);
    rd(4'd1, d); settle(4);
    rd(4'd13, d); check("R10 one event per edge", d, 8'h00);
    set_strobe(1'b1);
  endtask

  task automatic t_same_cycle;
    logic [7:0] d;
    @(negedge clk); strobe = 1'b0;
    @(posedge clk); @(posedge clk);
    @(negedge clk); cs = 1'b1; rw = 1'b1; addr = 4'd1;
    @(negedge clk); cs = 1'b0;
    settle(2);
    rd(4'd13, d); check("R9 set wins over clear", d, 8'h82);
    check("R9 irq asserted", {7'd0, irq_n}, 8'h00);
    rd(4'd1, d); set_strobe(1'b1);
  endtask

  task automatic t_rise_mode;
    logic [7:0] d;
    wr(4'd12, 8'h01);
    set_strobe(1'b0);
    rd(4'd13, d); check("R2 falling ignored in rising mode", d, 8'h00);
    set_strobe(1'b1);
    rd(4'd13, d); check("R2 rising sets flag", d, 8'h82);
    rd(4'd1, d);
  endtask

  task automatic t_handshake;
    wr(4'd12, 8'h0C);
    check("R8 mode 110 low", {7'd0, hs_out}, 8'h00);
    wr(4'd12, 8'h0E);
    check("R8 mode 111 high", {7'd0, hs_out}, 8'h01);
    wr(4'd12, 8'h0C);
    wr(4'd12, 8'h08);
    check("R8 other mode high", {7'd0, hs_out}, 8'h01);
  endtask

  initial begin
    #1_000_000;
    errors++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    settle(4);
    @(negedge clk); rst = 1'b0;
    settle(2);
    t_reset;
    t_port_read;
    t_fall_edge;
    t_write_clears;
    t_enable_gate;
    t_lost_edge;
    t_short_pulse;
    t_same_cycle;
    t_rise_mode;
    t_handshake;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule